// File: doc/BRIEF.md
# Boot Image Header Loader

This block is the hardware sequencer that brings up a system from a boot image held in byte-addressed storage. After a start pulse it fetches a fixed-layout header through a storage read port and checks a signature word. It then validates the length, source and pair-count fields. If the image is sound, it issues a list of 32-bit register writes taken from address/data pairs in the image. After that it copies a block-aligned payload from storage into memory and publishes the execution start address.

A rejected image ends the sequence in a sticky failure state. In that state a hardware reset request is raised and the storage enable is dropped. The storage itself is modelled outside the block: a request/valid read port returns one byte at a time, with any latency. Two separate write ports, one for configuration registers and one for memory, each carry one 32-bit write per request/acknowledge handshake.

Top module: `boot_hdr_loader`

## Requirements
- R1: After reset, `done`, `reset_req`, `rd_req`, `cfg_wr_req` and `mem_wr_req` are 0, `exec_addr` is 0 and `stor_en` is 1.
- R2: The 32-bit word at storage offset 0x40 must equal 0x424F4F54. Any other value ends in failure: `reset_req` is 1, `stor_en` is 0 and no write is issued.
- R3: Header words are assembled most-significant byte first. Fields are: payload length at 0x48, source offset at 0x50, target address at 0x58, execution address at 0x60 and pair count N at 0x68.
- R4: N outside 1..MAX_PAIRS (default 1024) makes the image invalid; N = 1024 is accepted.
- R5: A payload length or source offset that is not a multiple of BLOCK_BYTES (default 512) is invalid. So is a length above 0x80000000. A length of 0 is valid and copies nothing.
- R6: For pair i (from 1), the register address is read at 0x80 + 8*(i-1) and the data 4 bytes later. The N writes appear on the configuration port in pair order, and all of them complete before any memory write.
- R7: Payload bytes from the source offset are packed four per word, with the first byte in bits 31:24. Word j is written to target + 4*j, and exactly length/4 writes are issued.
- R8: `done` rises and `exec_addr` shows the word from 0x60 only after the last memory write has been acknowledged. Before that, `exec_addr` stays 0.
- R9: A read request keeps its address stable until `rd_valid`. A write request keeps its address and data stable until its acknowledge.
- R10: The done and failure states are sticky until reset. A start pulse in either state causes no read and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins loading |
| stor_en | output | 1 | Storage interface enable, low after a rejected image |
| rd_req | output | 1 | Byte read request, held until `rd_valid` |
| rd_addr | output | 32 | Byte offset in storage |
| rd_valid | input | 1 | Read byte is present on `rd_data` |
| rd_data | input | 8 | Read byte |
| cfg_wr_req | output | 1 | Configuration register write request |
| cfg_wr_addr | output | 32 | Configuration register address |
| cfg_wr_data | output | 32 | Configuration register data |
| cfg_wr_ack | input | 1 | Configuration write accepted |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Memory word address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_ack | input | 1 | Memory write accepted |
| done | output | 1 | Image loaded, sticky |
| exec_addr | output | 32 | Execution start address, valid with `done` |
| reset_req | output | 1 | Hardware reset request after a rejected image, sticky |

## Verification
A directed image with three pairs, and random valid images with varied pair counts, payload sizes, source blocks and handshake latencies, confirm three things: the header fields come from the right offsets, the pairs reach the configuration port in order before any memory write, and payload bytes are packed big-endian at increasing addresses. Separate images each break exactly one rule: a corrupted signature, N = 0, N = 1025, a length off by one byte, a misaligned source, and a length just above 2 Gbytes. Each must produce the reset request with no write at all. This tells apart a missing check from a check on the wrong field. The limit N = 1024 with a zero-length payload, and a start pulse after completion, cover the boundary and sticky cases.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] BOOT_SIG = 32'h424F_4F54;
  localparam logic [WORD_W-1:0] HDR_BASE = 32'h0000_0040;
  localparam logic [WORD_W-1:0] CFG_BASE = 32'h0000_0080;
  localparam int HDR_WORDS = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_HDR,
    ST_CHECK,
    ST_CONFIG,
    ST_COPY,
    ST_DONE,
    ST_FAIL
  } boot_state_e;
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/boot_word_reader.sv
module boot_word_reader
  import boot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] base,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data
);
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    word_d = word_q;
    if (!busy_q && go) begin
      busy_d = 1'b1;
      addr_d = base;
      cnt_d  = 2'd0;
    end else if (busy_q && rd_valid) begin
      word_d = {word_q[WORD_W-9:0], rd_data};
      addr_d = addr_q + 1'b1;
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == 2'd3) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      word_q <= word_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign word    = word_q;
  assign rd_req  = busy_q;
  assign rd_addr = addr_q;

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
  // R9
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !done);
endmodule

// File: rtl/boot_wr_port.sv
module boot_wr_port
  import boot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] addr_in,
  input  logic [WORD_W-1:0] data_in,
  output logic              busy,
  output logic              req,
  output logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] data,
  input  logic              ack
);
  logic              req_q, req_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;

  always_comb begin
    req_d  = req_q;
    addr_d = addr_q;
    data_d = data_q;
    if (req_q && ack) req_d = 1'b0;
    if (load) begin
      req_d  = 1'b1;
      addr_d = addr_in;
      data_d = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy = req_q;
  assign req  = req_q;
  assign addr = addr_q;
  assign data = data_q;

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr) && $stable(data)));
  // R9
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !req);
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_pkg::*;
#(
  parameter int          BLOCK_BYTES = 512,
  parameter int          MAX_PAIRS   = 1024,
  parameter logic [31:0] MAX_LEN     = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_go,
  output logic [WORD_W-1:0] rd_base,
  input  logic              rd_busy,
  input  logic              rd_done,
  input  logic [WORD_W-1:0] rd_word,
  output logic              cfg_load,
  output logic [WORD_W-1:0] cfg_addr,
  output logic [WORD_W-1:0] cfg_data,
  input  logic              cfg_busy,
  output logic              mem_load,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  input  logic              mem_busy,
  output logic              done,
  output logic [WORD_W-1:0] exec_addr,
  output logic              reset_req,
  output logic              stor_en
);
  localparam int BLK_SH = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(MAX_PAIRS + 1);
  localparam int WC_W   = WORD_W - 2;

  boot_state_e       state_q, state_d;
  logic [1:0]        sub_q, sub_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WC_W-1:0]   wcnt_q, wcnt_d;
  logic [WORD_W-1:0] sig_q, sig_d, len_q, len_d, src_q, src_d;
  logic [WORD_W-1:0] tgt_q, tgt_d, exe_q, exe_d, npair_q, npair_d;
  logic [WORD_W-1:0] cfga_q, cfga_d;
  logic              hdr_ok, last_pair, last_word, no_words, want_rd;
  logic [WC_W-1:0]   words;

  assign words     = len_q[WORD_W-1:2];
  assign no_words  = (words == '0);
  assign last_word = (wcnt_q == words - 1'b1);
  assign last_pair = (idx_q == IDX_W'(npair_q - 1));
  assign hdr_ok    = (sig_q == BOOT_SIG) &&
                     (npair_q != '0) && (npair_q <= WORD_W'(MAX_PAIRS)) &&
                     (len_q[BLK_SH-1:0] == '0) && (src_q[BLK_SH-1:0] == '0) &&
                     (len_q <= MAX_LEN);

  always_comb begin
    want_rd = 1'b0;
    rd_base = '0;
    case (state_q)
      ST_READ_HDR: begin
        want_rd = 1'b1;
        rd_base = HDR_BASE + (WORD_W'(idx_q) << 3);
      end
      ST_CONFIG: begin
        want_rd = (sub_q != 2'd2);
        rd_base = CFG_BASE + (WORD_W'(idx_q) << 3) + ((sub_q == 2'd1) ? 32'd4 : 32'd0);
      end
      ST_COPY: begin
        want_rd = (sub_q == 2'd0);
        rd_base = src_q + (WORD_W'(wcnt_q) << 2);
      end
      default: ;
    endcase
  end

  assign rd_go = want_rd && !rd_busy && !rd_done;

  always_comb begin
    state_d  = state_q;
    sub_d    = sub_q;
    idx_d    = idx_q;
    wcnt_d   = wcnt_q;
    sig_d    = sig_q;
    len_d    = len_q;
    src_d    = src_q;
    tgt_d    = tgt_q;
    exe_d    = exe_q;
    npair_d  = npair_q;
    cfga_d   = cfga_q;
    cfg_load = 1'b0;
    mem_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_READ_HDR;
          idx_d   = '0;
        end
      end
      ST_READ_HDR: begin
        if (rd_done) begin
          case (idx_q[2:0])
            3'd0:    sig_d   = rd_word;
            3'd1:    len_d   = rd_word;
            3'd2:    src_d   = rd_word;
            3'd3:    tgt_d   = rd_word;
            3'd4:    exe_d   = rd_word;
            default: npair_d = rd_word;
          endcase
          if (idx_q == IDX_W'(HDR_WORDS - 1)) begin
            state_d = ST_CHECK;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_CHECK: begin
        state_d = hdr_ok ? ST_CONFIG : ST_FAIL;
        sub_d   = 2'd0;
        idx_d   = '0;
        wcnt_d  = '0;
      end
      ST_CONFIG: begin
        case (sub_q)
          2'd0: if (rd_done) begin
            cfga_d = rd_word;
            sub_d  = 2'd1;
          end
          2'd1: if (rd_done) begin
            cfg_load = 1'b1;
            sub_d    = 2'd2;
          end
          default: if (!cfg_busy) begin
            sub_d = 2'd0;
            if (last_pair) begin
              idx_d   = '0;
              state_d = no_words ? ST_DONE : ST_COPY;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        endcase
      end
      ST_COPY: begin
        if (sub_q == 2'd0) begin
          if (rd_done) begin
            mem_load = 1'b1;
            sub_d    = 2'd1;
          end
        end else if (!mem_busy) begin
          sub_d = 2'd0;
          if (last_word) state_d = ST_DONE;
          else           wcnt_d  = wcnt_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      wcnt_q  <= '0;
      sig_q   <= '0;
      len_q   <= '0;
      src_q   <= '0;
      tgt_q   <= '0;
      exe_q   <= '0;
      npair_q <= '0;
      cfga_q  <= '0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      wcnt_q  <= wcnt_d;
      sig_q   <= sig_d;
      len_q   <= len_d;
      src_q   <= src_d;
      tgt_q   <= tgt_d;
      exe_q   <= exe_d;
      npair_q <= npair_d;
      cfga_q  <= cfga_d;
    end
  end

  assign cfg_addr  = cfga_q;
  assign cfg_data  = rd_word;
  assign mem_addr  = tgt_q + (WORD_W'(wcnt_q) << 2);
  assign mem_data  = rd_word;
  assign done      = (state_q == ST_DONE);
  assign exec_addr = done ? exe_q : '0;
  assign reset_req = (state_q == ST_FAIL);
  assign stor_en   = (state_q != ST_FAIL);

  // R6
  cfg_before_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_load |-> !cfg_busy);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_busy && !cfg_busy && !rd_busy));
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);
endmodule

// File: rtl/boot_hdr_loader.sv
module boot_hdr_loader
  import boot_pkg::*;
#(
  parameter int          BLOCK_BYTES = 512,
  parameter int          MAX_PAIRS   = 1024,
  parameter logic [31:0] MAX_LEN     = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        stor_en,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_valid,
  input  logic [7:0]  rd_data,
  output logic        cfg_wr_req,
  output logic [31:0] cfg_wr_addr,
  output logic [31:0] cfg_wr_data,
  input  logic        cfg_wr_ack,
  output logic        mem_wr_req,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        mem_wr_ack,
  output logic        done,
  output logic [31:0] exec_addr,
  output logic        reset_req
);
  logic              rst_sync_n;
  logic              rd_go, rd_busy, rd_done;
  logic [WORD_W-1:0] rd_base, rd_word;
  logic              cfg_load, cfg_busy, mem_load, mem_busy;
  logic [WORD_W-1:0] cfg_a, cfg_d, mem_a, mem_d;

  boot_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  boot_word_reader u_rd (
    .clk(clk), .rst_n(rst_sync_n), .go(rd_go), .base(rd_base),
    .busy(rd_busy), .done(rd_done), .word(rd_word),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  boot_seq #(.BLOCK_BYTES(BLOCK_BYTES), .MAX_PAIRS(MAX_PAIRS), .MAX_LEN(MAX_LEN)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .rd_go(rd_go), .rd_base(rd_base), .rd_busy(rd_busy), .rd_done(rd_done), .rd_word(rd_word),
    .cfg_load(cfg_load), .cfg_addr(cfg_a), .cfg_data(cfg_d), .cfg_busy(cfg_busy),
    .mem_load(mem_load), .mem_addr(mem_a), .mem_data(mem_d), .mem_busy(mem_busy),
    .done(done), .exec_addr(exec_addr), .reset_req(reset_req), .stor_en(stor_en)
  );

  boot_wr_port u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .load(cfg_load), .addr_in(cfg_a), .data_in(cfg_d),
    .busy(cfg_busy), .req(cfg_wr_req), .addr(cfg_wr_addr), .data(cfg_wr_data), .ack(cfg_wr_ack)
  );

  boot_wr_port u_mem (
    .clk(clk), .rst_n(rst_sync_n), .load(mem_load), .addr_in(mem_a), .data_in(mem_d),
    .busy(mem_busy), .req(mem_wr_req), .addr(mem_wr_addr), .data(mem_wr_data), .ack(mem_wr_ack)
  );

  // R6
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_req |-> !cfg_wr_req);
  // R2
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reset_req |-> (!rd_req && !stor_en && !cfg_wr_req && !mem_wr_req));
  // R8
  exec_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |-> (exec_addr == '0));
endmodule

// File: tb/boot_hdr_loader_tb.sv
`timescale 1ns/1ps
module boot_hdr_loader_tb;
  localparam int SSZ = 16384;
  localparam logic [31:0] SIG = 32'h424F4F54;

  logic        clk, rst_n, start;
  logic        stor_en, rd_req, rd_valid;
  logic [31:0] rd_addr;
  logic [7:0]  rd_data;
  logic        cfg_wr_req, cfg_wr_ack, mem_wr_req, mem_wr_ack;
  logic [31:0] cfg_wr_addr, cfg_wr_data, mem_wr_addr, mem_wr_data;
  logic        done, reset_req;
  logic [31:0] exec_addr;

  int unsigned n_tests = 0, n_fail = 0, cycles = 0;
  logic [7:0]  stor [0:SSZ-1];
  logic [31:0] cfg_la [0:1023];
  logic [31:0] cfg_ld [0:1023];
  logic [31:0] mem_la [0:511];
  logic [31:0] mem_ld [0:511];
  int unsigned cfg_n, mem_n, order_err;
  int unsigned rdly, cdly, mdly;

  boot_hdr_loader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stor_en(stor_en),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_wr_req(cfg_wr_req), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data), .cfg_wr_ack(cfg_wr_ack),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .done(done), .exec_addr(exec_addr), .reset_req(reset_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 195000) begin
      n_tests = n_tests + 1;
      n_fail  = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <195000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // storage and write responders, driven away from the active edge
  always @(negedge clk) begin
    if (!rd_req || rd_valid) begin
      rd_valid = 1'b0;
      rdly = $urandom % 3;
    end else if (rdly == 0) begin
      rd_valid = 1'b1;
      rd_data  = stor[rd_addr % SSZ];
    end else rdly = rdly - 1;

    if (!cfg_wr_req || cfg_wr_ack) begin
      cfg_wr_ack = 1'b0;
      cdly = $urandom % 4;
    end else if (cdly == 0) begin
      cfg_wr_ack = 1'b1;
      if (mem_n != 0) order_err = order_err + 1;
      if (cfg_n < 1024) begin
        cfg_la[cfg_n] = cfg_wr_addr;
        cfg_ld[cfg_n] = cfg_wr_data;
      end
      cfg_n = cfg_n + 1;
    end else cdly = cdly - 1;

    if (!mem_wr_req || mem_wr_ack) begin
      mem_wr_ack = 1'b0;
      mdly = $urandom % 4;
    end else if (mdly == 0) begin
      mem_wr_ack = 1'b1;
      if (mem_n < 512) begin
        mem_la[mem_n] = mem_wr_addr;
        mem_ld[mem_n] = mem_wr_data;
      end
      mem_n = mem_n + 1;
    end else mdly = mdly - 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put32(input int unsigned a, input logic [31:0] v);
    stor[a]   = v[31:24];
    stor[a+1] = v[23:16];
    stor[a+2] = v[15:8];
    stor[a+3] = v[7:0];
  endtask

  function automatic logic [31:0] get32(input int unsigned a);
    return {stor[a], stor[a+1], stor[a+2], stor[a+3]};
  endfunction

  task automatic build(input logic [31:0] sig, input logic [31:0] len, input logic [31:0] src,
                       input logic [31:0] tgt, input logic [31:0] exe, input logic [31:0] np);
    for (int i = 0; i < SSZ; i++) stor[i] = 8'($urandom);
    put32(32'h40, sig); put32(32'h48, len); put32(32'h50, src);
    put32(32'h58, tgt); put32(32'h60, exe); put32(32'h68, np);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cfg_n = 0; mem_n = 0; order_err = 0;
  endtask

  task automatic run();
    int unsigned t;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && !reset_req && t < 60000) begin
      @(negedge clk); t++;
    end
    check(t < 60000, "R8 completion", t, 60000);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_fail(input string tag);
    check(reset_req === 1'b1, {tag, " reset_req"}, 32'(reset_req), 1);
    check(stor_en === 1'b0, "R2 stor_en low on failure", 32'(stor_en), 0);
    check(done === 1'b0, {tag, " done low"}, 32'(done), 0);
    check(cfg_n == 0 && mem_n == 0, {tag, " no writes"}, cfg_n + mem_n, 0);
  endtask

  task automatic expect_ok(input logic [31:0] len, input logic [31:0] src,
                           input logic [31:0] tgt, input logic [31:0] exe, input int unsigned np);
    int unsigned bad = 0;
    check(done === 1'b1 && reset_req === 1'b0, "R8 done set", 32'(done), 1);
    check(exec_addr === exe, "R8 exec_addr from 0x60 (R3)", exec_addr, exe);
    check(cfg_n == np, "R6 config write count", cfg_n, np);
    for (int i = 0; i < np && i < 1024; i++)
      if (cfg_la[i] !== get32(32'h80 + 8*i) || cfg_ld[i] !== get32(32'h84 + 8*i)) bad++;
    check(bad == 0, "R6 config pairs in order", bad, 0);
    check(order_err == 0, "R6 config before copy", order_err, 0);
    check(mem_n == len / 4, "R7 memory write count", mem_n, len / 4);
    bad = 0;
    for (int j = 0; j < len / 4 && j < 512; j++)
      if (mem_la[j] !== tgt + 4*j || mem_ld[j] !== get32(src + 4*j)) bad++;
    check(bad == 0, "R7 payload packing and addresses", bad, 0);
  endtask

  initial begin
    logic [31:0] tgt, exe, len, src;
    int unsigned np, cn, mn;
    rd_valid = 0; rd_data = 0; cfg_wr_ack = 0; mem_wr_ack = 0;
    cfg_n = 0; mem_n = 0; order_err = 0;
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    check(done === 0 && reset_req === 0 && exec_addr === 0, "R1 outputs in reset",
          {30'd0, done, reset_req}, 0);
    check(rd_req === 0 && cfg_wr_req === 0 && mem_wr_req === 0 && stor_en === 1,
          "R1 idle ports in reset", {28'd0, rd_req, cfg_wr_req, mem_wr_req, stor_en}, 1);

    // directed valid image with 3 pairs
    reset_dut();
    build(SIG, 32'd512, 32'h400, 32'h1000_0000, 32'h1000_0100, 32'd3);
    run();
    expect_ok(32'd512, 32'h400, 32'h1000_0000, 32'h1000_0100, 3);
    cn = cfg_n; mn = mem_n;
    // R10 start after done
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (200) @(negedge clk);
    check(cfg_n == cn && mem_n == mn && done === 1, "R10 start ignored after done", cfg_n + mem_n, cn + mn);

    // R2 bad signature
    reset_dut();
    build(32'h424F4F55, 32'd512, 32'h400, 32'h2000, 32'h2000, 32'd3);
    run();
    expect_fail("R2 bad signature");
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (50) @(negedge clk);
    check(reset_req === 1 && rd_req === 0 && cfg_n == 0, "R10 start ignored after fail", cfg_n, 0);

    // R4 pair count limits
    reset_dut();
    build(SIG, 32'd512, 32'h400, 32'h2000, 32'h2000, 32'd0);
    run();
    expect_fail("R4 N=0");
    reset_dut();
    build(SIG, 32'd512, 32'h400, 32'h2000, 32'h2000, 32'd1025);
    run();
    expect_fail("R4 N=1025");

    // R5 alignment and size
    reset_dut();
    build(SIG, 32'd513, 32'h400, 32'h2000, 32'h2000, 32'd2);
    run();
    expect_fail("R5 misaligned length");
    reset_dut();
    build(SIG, 32'd512, 32'h410, 32'h2000, 32'h2000, 32'd2);
    run();
    expect_fail("R5 misaligned source");
    reset_dut();
    build(SIG, 32'h8000_0200, 32'h400, 32'h2000, 32'h2000, 32'd2);
    run();
    expect_fail("R5 length above 2G");

    // R4 N=1024 with zero-length payload (R5)
    reset_dut();
    build(SIG, 32'd0, 32'd0, 32'h3000, 32'hABCD_0000, 32'd1024);
    run();
    expect_ok(32'd0, 32'd0, 32'h3000, 32'hABCD_0000, 1024);

    // random valid images (R3, R6, R7)
    for (int k = 0; k < 3; k++) begin
      np  = 1 + $urandom % 6;
      len = ((k == 1) ? 32'd1024 : 32'd512);
      src = (4 + $urandom % 24) * 512;
      tgt = {$urandom} & 32'hFFFF_FFFC;
      exe = $urandom;
      reset_dut();
      build(SIG, len, src, tgt, exe, np);
      run();
      expect_ok(len, src, tgt, exe, np);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule